// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronisation Unit

This unit turns the system clock into CAN time quanta and runs every nominal bit through three phases. It watches the receive line for falling edges and uses them to re-align its own bit grid to the grid of the bus. At the sample point it hands the bus level to the bit stream processor. At the start of each new bit it takes the next transmit bit from that processor and places it on `tx`.

A programmable prescaler sets the quantum length. Each bit is one sync quantum, a first segment (the propagation delay plus phase segment 1) and a second segment (phase segment 2). The controller state machine has three states:

- `BT_SYNC` is the one-quantum sync segment. It always moves to `BT_SEG1` and reloads both segment lengths.
- `BT_SEG1` advances to `BT_SEG2` after its last quantum and raises the sample strobe at that point.
- `BT_SEG2` returns to `BT_SYNC` after its last quantum and loads the transmit bit.

Hard synchronisation bypasses the case statement. The quantum that carries the edge counts as the sync segment, and the machine goes straight to `BT_SEG1`.

Top module: `can_bit_timer`

## Requirements
- R1: One time quantum lasts BRP system clocks, where BRP = `cfg_rate[5:0]` + 1. A nominal bit therefore lasts (1 + TSEG1 + TSEG2) × BRP clocks.
- R2: Each configuration field holds its value minus one:
  - SJW = `cfg_rate[7:6]` + 1
  - TSEG1 = `cfg_seg[3:0]` + 1 (range 1..16)
  - TSEG2 = `cfg_seg[6:4]` + 1 (range 1..8)
  - The setting TSEG1 = 5, TSEG2 = 4, SJW = 4 gives a 10-quantum bit.
- R3: `rx` is compared at each quantum tick with its level at the previous tick. Only a change from 1 (recessive) to 0 (dominant) counts as an edge. A rising change has no effect on the bit timing.
- R4: The effective jump width is min(SJW, TSEG1, TSEG2).
- R5: An edge seen at the k-th quantum of `BT_SEG1` (k counted from 1) lengthens that segment by min(k, effective jump width) quanta.
- R6: An edge in `BT_SEG2` that leaves r quanta of the segment after it shortens the segment by min(r, effective jump width). When r is no larger than the jump width, the bit ends with the edge quantum.
- R7: An edge seen in the `BT_SYNC` quantum causes no adjustment.
- R8: At most one resynchronisation is made per bit. Later edges in the same bit do nothing.
- R9: No resynchronisation is made while `tx` is 0 (dominant).
- R10: While `hard_sync_mode` is 1, an edge restarts the bit: its quantum becomes the sync segment, `BT_SEG1` follows with full length, and no resynchronisation is made.
- R11: `tx_next_bit` is captured on the transition from `BT_SEG2` to `BT_SYNC` and driven on `tx` for the whole bit. While `bus_off` is 1, `tx` is 1.
- R12: `sample_stb` pulses for one clock after the last `BT_SEG1` quantum. `sample_bit` holds the `rx` level at that tick. In reset, `tx` = 1 and `sample_stb` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_rate | input | 8 | {SJW-1, BRP-1} |
| cfg_seg | input | 7 | {TSEG2-1, TSEG1-1} |
| rx | input | 1 | Receive line, 0 = dominant |
| tx | output | 1 | Transmit line |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Bus level captured at the sample point |
| tx_next_bit | input | 1 | Next bit from the bit stream processor |
| hard_sync_mode | input | 1 | Edges cause hard synchronisation instead of resynchronisation |
| bus_off | input | 1 | Forces `tx` recessive |

## Verification
The assertions assume that `cfg_rate` and `cfg_seg` change only while reset is held. The prescaler bound and the segment-length bounds are measured against the current configuration, so a change in mid-bit would break them. The bench writes a new configuration only during a reset pulse. It drives `rx` on the falling clock edge, a fixed number of quanta after an observed sample strobe, so each edge lands in a chosen state and counter value.

// File: rtl/cbt_pkg.sv
`timescale 1ns/1ps
package cbt_pkg;
    typedef enum logic [1:0] {
        BT_SYNC = 2'd0,
        BT_SEG1 = 2'd1,
        BT_SEG2 = 2'd2
    } bt_state_t;
endpackage

// File: rtl/cbt_prescaler.sv
`timescale 1ns/1ps
module cbt_prescaler #(
    parameter int BRP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BRP_W-1:0] brp_m1,
    output logic             tq_tick
);
    logic [BRP_W-1:0] pre_cnt;

    assign tq_tick = (pre_cnt == brp_m1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (tq_tick) pre_cnt <= '0;
        else              pre_cnt <= pre_cnt + BRP_W'(1);
    end

    AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n) pre_cnt <= brp_m1); // R1
endmodule

// File: rtl/cbt_edge_det.sv
`timescale 1ns/1ps
module cbt_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic tq_tick,
    input  logic rx,
    output logic fall
);
    logic rx_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rx_last <= 1'b1;
        else if (tq_tick) rx_last <= rx;
    end

    assign fall = tq_tick && rx_last && !rx;

    AST_FALL_LEAVES_DOMINANT: assert property (@(posedge clk) disable iff (!rst_n) fall |=> !rx_last); // R3
endmodule

// File: rtl/cbt_jump_limit.sv
`timescale 1ns/1ps
module cbt_jump_limit #(
    parameter int CNT_W = 6,
    parameter int SJW_W = 2
) (
    input  logic [SJW_W-1:0] sjw_m1,
    input  logic [CNT_W-1:0] tseg1,
    input  logic [CNT_W-1:0] tseg2,
    output logic [CNT_W-1:0] sjw_eff
);
    logic [CNT_W-1:0] sjw_full;
    logic [CNT_W-1:0] seg_min;

    always_comb begin
        sjw_full = CNT_W'(sjw_m1) + CNT_W'(1);
        seg_min  = (tseg1 < tseg2) ? tseg1 : tseg2;
        sjw_eff  = (sjw_full < seg_min) ? sjw_full : seg_min;
    end
endmodule

// File: rtl/can_bit_timer.sv
`timescale 1ns/1ps
module can_bit_timer #(
    parameter int BRP_W   = 6,
    parameter int SJW_W   = 2,
    parameter int TSEG1_W = 4,
    parameter int TSEG2_W = 3,
    parameter int CNT_W   = 6,
    localparam int RATE_W = BRP_W + SJW_W,
    localparam int SEG_W  = TSEG1_W + TSEG2_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] cfg_rate,
    input  logic [SEG_W-1:0]  cfg_seg,
    input  logic              rx,
    output logic              tx,
    output logic              sample_stb,
    output logic              sample_bit,
    input  logic              tx_next_bit,
    input  logic              hard_sync_mode,
    input  logic              bus_off
);
    import cbt_pkg::*;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic             tq_tick, fall;
    logic [CNT_W-1:0] tseg1, tseg2, sjw_eff;
    bt_state_t        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n, seg1_len, seg1_len_n, seg2_len, seg2_len_n;
    logic [CNT_W-1:0] len1, len2, rem2, late_step;
    logic             resync_done, resync_done_n, resync_ok, hard_hit;
    logic             do_sample, load_tx, tx_bit;

    assign tseg1 = CNT_W'(cfg_seg[TSEG1_W-1:0]) + ONE;
    assign tseg2 = CNT_W'(cfg_seg[SEG_W-1:TSEG1_W]) + ONE;

    cbt_prescaler #(.BRP_W(BRP_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .brp_m1(cfg_rate[BRP_W-1:0]), .tq_tick(tq_tick)
    );

    cbt_edge_det u_edge (
        .clk(clk), .rst_n(rst_n), .tq_tick(tq_tick), .rx(rx), .fall(fall)
    );

    cbt_jump_limit #(.CNT_W(CNT_W), .SJW_W(SJW_W)) u_jump (
        .sjw_m1(cfg_rate[RATE_W-1:BRP_W]), .tseg1(tseg1), .tseg2(tseg2), .sjw_eff(sjw_eff)
    );

    assign hard_hit  = fall && hard_sync_mode;
    assign resync_ok = fall && !hard_sync_mode && !resync_done && tx;

    // next-state logic
    always_comb begin
        state_n       = state;
        cnt_n         = cnt;
        seg1_len_n    = seg1_len;
        seg2_len_n    = seg2_len;
        resync_done_n = resync_done;
        do_sample     = 1'b0;
        load_tx       = 1'b0;
        rem2          = seg2_len - cnt - ONE;
        late_step     = ((cnt + ONE) < sjw_eff) ? (cnt + ONE) : sjw_eff;
        len1          = seg1_len;
        len2          = seg2_len;
        if (resync_ok) begin
            len1 = seg1_len + late_step;
            len2 = (rem2 > sjw_eff) ? (seg2_len - sjw_eff) : (cnt + ONE);
        end
        if (tq_tick) begin
            if (hard_hit) begin
                state_n       = BT_SEG1;
                cnt_n         = '0;
                seg1_len_n    = tseg1;
                seg2_len_n    = tseg2;
                resync_done_n = 1'b0;
            end else begin
                unique case (state)
                    BT_SYNC: begin
                        state_n       = BT_SEG1;
                        cnt_n         = '0;
                        seg1_len_n    = tseg1;
                        seg2_len_n    = tseg2;
                        resync_done_n = 1'b0;
                    end
                    BT_SEG1: begin
                        seg1_len_n = len1;
                        if (resync_ok) resync_done_n = 1'b1;
                        if (cnt == len1 - ONE) begin
                            state_n   = BT_SEG2;
                            cnt_n     = '0;
                            do_sample = 1'b1;
                        end else begin
                            cnt_n = cnt + ONE;
                        end
                    end
                    BT_SEG2: begin
                        seg2_len_n = len2;
                        if (resync_ok) resync_done_n = 1'b1;
                        if (cnt == len2 - ONE) begin
                            state_n = BT_SYNC;
                            cnt_n   = '0;
                            load_tx = 1'b1;
                        end else begin
                            cnt_n = cnt + ONE;
                        end
                    end
                    default: state_n = BT_SYNC;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= BT_SYNC;
            cnt         <= '0;
            seg1_len    <= ONE;
            seg2_len    <= ONE;
            resync_done <= 1'b0;
        end else begin
            state       <= state_n;
            cnt         <= cnt_n;
            seg1_len    <= seg1_len_n;
            seg2_len    <= seg2_len_n;
            resync_done <= resync_done_n;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
            sample_bit <= 1'b1;
            tx_bit     <= 1'b1;
        end else begin
            sample_stb <= do_sample;
            if (do_sample) sample_bit <= rx;
            if (load_tx)   tx_bit     <= tx_next_bit;
        end
    end

    assign tx = bus_off | tx_bit;

    AST_SJW_WITHIN_SEGS: assert property (@(posedge clk) disable iff (!rst_n) (sjw_eff != '0) && (sjw_eff <= tseg1) && (sjw_eff <= tseg2)); // R4
    AST_SEG1_STRETCH_MAX: assert property (@(posedge clk) disable iff (!rst_n) (state == BT_SEG1) |-> (seg1_len <= tseg1 + sjw_eff)); // R5
    AST_SEG2_SHRINK_MAX: assert property (@(posedge clk) disable iff (!rst_n) (state == BT_SEG2) |-> (seg2_len + sjw_eff >= tseg2)); // R6
    AST_SINGLE_JUMP: assert property (@(posedge clk) disable iff (!rst_n) (state == BT_SEG1 && resync_done && !hard_sync_mode) |=> (state != BT_SEG1 || $stable(seg1_len))); // R8
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sample_stb |=> !sample_stb); // R12
    AST_TX_AT_BIT_START: assert property (@(posedge clk) disable iff (!rst_n) (tx_bit != $past(tx_bit)) |-> (state == BT_SYNC)); // R11
endmodule

// File: tb/can_bit_timer_test.sv
`timescale 1ns/1ps
module can_bit_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] cfg_rate = 8'h00;
    logic [6:0] cfg_seg = 7'h00;
    logic       rx = 1'b1;
    logic       tx, sample_stb, sample_bit;
    logic       tx_next_bit = 1'b1;
    logic       hard_sync_mode = 1'b0;
    logic       bus_off = 1'b0;

    int checks = 0;
    int fails = 0;
    int last_gap = 0;
    logic last_bit;
    bit done = 0;

    always #5 clk = ~clk;

    can_bit_timer uut (
        .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_seg(cfg_seg),
        .rx(rx), .tx(tx), .sample_stb(sample_stb), .sample_bit(sample_bit),
        .tx_next_bit(tx_next_bit), .hard_sync_mode(hard_sync_mode), .bus_off(bus_off)
    );

    typedef struct packed {
        int t1; int t2; int sjw; int brp; int gap;
    } vec_t;

    // gap = (1 + t1 + t2) * brp
    localparam vec_t VECS [6] = '{
        '{5, 4, 4, 1, 10},
        '{6, 4, 2, 1, 11},
        '{16, 8, 4, 1, 25},
        '{1, 1, 1, 1, 3},
        '{3, 2, 1, 3, 18},
        '{8, 3, 2, 2, 24}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Configure, reset, find a sample strobe, then count clocks to the next
    // one while dropping/raising rx at the given clock offsets (0 = unused).
    task automatic run_case(input int t1, input int t2, input int sjw, input int brp,
                            input bit hs, input bit txn, input bit boff,
                            input int f1, input int r1, input int f2);
        cfg_rate       = {2'(sjw - 1), 6'(brp - 1)};
        cfg_seg        = {3'(t2 - 1), 4'(t1 - 1)};
        hard_sync_mode = hs;
        tx_next_bit    = txn;
        bus_off        = boff;
        rx             = 1'b1;
        rst_n          = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        do @(negedge clk); while (!sample_stb);
        last_gap = 0;
        while (1) begin
            @(negedge clk);
            last_gap++;
            if (last_gap == f1) rx = 1'b0;
            if (last_gap == r1) rx = 1'b1;
            if (last_gap == f2) rx = 1'b0;
            if (sample_stb || last_gap > 5000) break;
        end
        last_bit = sample_bit;
        rx = 1'b1;
    endtask

    initial begin
        // reset state, R12
        tx_next_bit = 1'b0;
        repeat (2) @(negedge clk);
        check("R12 reset tx", int'(tx), 1);
        check("R12 reset strobe", int'(sample_stb), 0);

        // table walk: R1 / R2 bit period, R12 sampled level, R11 tx follows next bit
        foreach (VECS[i]) begin
            run_case(VECS[i].t1, VECS[i].t2, VECS[i].sjw, VECS[i].brp, 1'b0, 1'b1, 1'b0, 0, 0, 0);
            check("R1 R2 bit period", last_gap, (1 + VECS[i].t1 + VECS[i].t2) * VECS[i].brp);
            check("R1 R2 table gap", last_gap, VECS[i].gap);
            check("R12 sampled recessive", int'(last_bit), 1);
            check("R11 tx recessive", int'(tx), 1);
        end

        // R5 late edge, k=2, SJW=2
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 6, 0, 0);
        check("R5 late edge k=2", last_gap, 13);
        check("R12 sampled dominant", int'(last_bit), 0);
        // R5 late edge, k=5 clipped to SJW=2
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 9, 0, 0);
        check("R5 late edge k=5", last_gap, 13);
        // R7 edge in sync quantum
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 4, 0, 0);
        check("R7 sync edge", last_gap, 11);
        // R8 second edge in the same bit
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 6, 7, 8);
        check("R8 one resync per bit", last_gap, 13);
        // R3 rising edge in SEG1 after a sync-quantum fall
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 4, 5, 0);
        check("R3 rising edge ignored", last_gap, 11);
        // R6 early edge, r=2 <= SJW=2: bit ends with edge quantum
        run_case(6, 4, 2, 1, 1'b0, 1'b1, 1'b0, 1, 0, 0);
        check("R6 early edge end", last_gap, 9);
        // R6 early edge, r=2 > SJW=1: shorten by one
        run_case(6, 4, 1, 1, 1'b0, 1'b1, 1'b0, 1, 0, 0);
        check("R6 early edge partial", last_gap, 10);
        // R4 SJW=4 clamped by TSEG2=2, edge at k=4
        run_case(6, 2, 4, 1, 1'b0, 1'b1, 1'b0, 6, 0, 0);
        check("R4 jump clamp", last_gap, 11);
        // R9 no resync while transmitting dominant
        run_case(6, 4, 2, 1, 1'b0, 1'b0, 1'b0, 6, 0, 0);
        check("R9 dominant tx no resync", last_gap, 11);
        check("R11 tx dominant", int'(tx), 0);
        // R11 bus-off forces recessive, so resync applies again
        run_case(6, 4, 2, 1, 1'b0, 1'b0, 1'b1, 6, 0, 0);
        check("R11 bus-off tx", int'(tx), 1);
        check("R11 bus-off resync", last_gap, 13);
        // R10 hard sync on an SEG2 edge
        run_case(6, 4, 2, 1, 1'b1, 1'b1, 1'b0, 1, 0, 0);
        check("R10 hard sync restart", last_gap, 8);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R12 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule